// File: doc/BRIEF.md
# Differential PSK Phase Encoder

This block takes modem line symbols one at a time and produces absolute constellation phase indices. Each accepted symbol is decoded, according to the selected line-coding mode, into a phase step measured in 45-degree units. That step is added to a running phase accumulator, and the sum is presented as the new absolute phase. An amplitude-class bit is presented alongside it. A downstream mapper turns the phase index and the amplitude class into I/Q values.

Five modes are supported. Two of them step in 45 degrees using three bits per symbol, and one of those is a fallback variant in which the amplitude bit is forced low. One mode steps in 90 degrees using two bits per symbol. One mode uses two-bit quadrant-change symbols. One mode uses four-bit symbols, where three bits set the phase step and the fourth bit picks one of two amplitudes. Selecting a different mode never disturbs the accumulated phase.

Top module: `dpsk_phase_encoder`

## Requirements
- R1: In mode 0 (tribit), sym_word[2:0] selects the step (bit 2 earliest in time): 001→0, 000→1, 010→2, 011→3, 111→4, 110→5, 100→6, 101→7 (units of 45°). The amplitude bit is 0.
- R2: In mode 1 (dibit, 90° steps), sym_word[1:0] selects the step: 00→0, 01→2, 11→4, 10→6. The amplitude bit is 0 and the step is always even.
- R3: In mode 2 (quadrant change), sym_word[1:0] selects the step: 01→0, 00→2, 10→4, 11→6. The amplitude bit is 0.
- R4: In mode 3 (quadbit), sym_word[2:0] selects the step using the R1 table, and sym_word[3] is driven out as the amplitude bit.
- R5: In mode 4 (fallback quadbit), sym_word[2:0] selects the step using the R1 table. sym_word[3] is ignored and the amplitude bit is always 0.
- R6: The output phase equals the previous output phase plus the decoded step, taken modulo 8.
- R7: pt_valid is high for exactly one cycle, in the cycle after each cycle in which sym_valid is high, and is low at all other times. pt_phase and pt_amp hold their values when no symbol is accepted.
- R8: A synchronous reset sets pt_phase to 0 and pt_valid to 0. A strobe that arrives while reset is high is ignored.
- R9: A change of mode while no symbol is accepted leaves the accumulator unchanged. The mode is sampled only together with a strobe.
- R10: Mode codes 5 to 7 decode to a step of 0 with the amplitude bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Line-coding mode select |
| sym_valid | input | 1 | Symbol strobe |
| sym_word | input | 4 | Symbol bits |
| pt_valid | output | 1 | Output point valid, one-cycle pulse |
| pt_phase | output | 3 | Absolute phase index in 45° units |
| pt_amp | output | 1 | Amplitude class |

## Verification
The phase index is cumulative, so the stimulus cannot check a table entry on its own. Each check is an absolute value that depends on every symbol since reset. The vector table is therefore one continuous run that visits every change code of every mode, changes mode partway through, and wraps the accumulator several times. The expected phases were worked out by hand along that run. The fallback mode is driven with the amplitude bit set, to show that the bit is dropped. Directed tests then show that idle mode changes and strobes during reset leave no trace in later points.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;

    localparam int PHASE_W = 3;
    localparam int SYM_W   = 4;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_TRIBIT   = 3'd0,
        MODE_DIBIT    = 3'd1,
        MODE_QUADRANT = 3'd2,
        MODE_QUADBIT  = 3'd3,
        MODE_FALLBACK = 3'd4
    } line_mode_e;

    typedef struct packed {
        logic [PHASE_W-1:0] step;
        logic               amp;
    } phase_change_t;

    // Gray-like tribit change table, 45-degree units
    function automatic logic [PHASE_W-1:0] tribit_step(input logic [2:0] b);
        case (b)
            3'b001:  return 3'd0;
            3'b000:  return 3'd1;
            3'b010:  return 3'd2;
            3'b011:  return 3'd3;
            3'b111:  return 3'd4;
            3'b110:  return 3'd5;
            3'b100:  return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    // 90-degree dibit table
    function automatic logic [PHASE_W-1:0] dibit_step(input logic [1:0] b);
        case (b)
            2'b00:   return 3'd0;
            2'b01:   return 3'd2;
            2'b11:   return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

    // quadrant-change dibit table
    function automatic logic [PHASE_W-1:0] quadrant_step(input logic [1:0] b);
        case (b)
            2'b01:   return 3'd0;
            2'b00:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/dpsk_change_decode.sv
module dpsk_change_decode
    import dpsk_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [SYM_W-1:0]  word,
    output phase_change_t     chg
);

    always_comb begin
        chg = '0;
        case (mode)
            MODE_TRIBIT:   chg.step = tribit_step(word[2:0]);
            MODE_DIBIT:    chg.step = dibit_step(word[1:0]);
            MODE_QUADRANT: chg.step = quadrant_step(word[1:0]);
            MODE_QUADBIT: begin
                chg.step = tribit_step(word[2:0]);
                chg.amp  = word[3];
            end
            MODE_FALLBACK: chg.step = tribit_step(word[2:0]);
            default:       chg = '0;   // R10: unused codes give no change
        endcase
    end

    // R2 / R3: the 90-degree modes only move by even steps
    always_comb begin
        if (mode == MODE_DIBIT || mode == MODE_QUADRANT)
            a_r2_even_step: assert (chg.step[0] == 1'b0);
    end

    // R5: fallback never raises the amplitude class
    always_comb begin
        if (mode == MODE_FALLBACK)
            a_r5_amp_low: assert (chg.amp == 1'b0);
    end

endmodule

// File: rtl/dpsk_phase_acc.sv
module dpsk_phase_acc
    import dpsk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  phase_change_t      chg,
    output logic               out_valid,
    output logic [PHASE_W-1:0] phase,
    output logic               amp
);

    logic [PHASE_W-1:0] phase_next;

    assign phase_next = phase + chg.step;   // wraps modulo 2**PHASE_W

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            amp       <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                phase <= phase_next;
                amp   <= chg.amp;
            end
        end
    end

    a_r7_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(phase) && $stable(amp)));

    a_r6_accumulate: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (phase == PHASE_W'($past(phase) + $past(chg.step))));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && phase == '0));

endmodule

// File: rtl/dpsk_phase_encoder.sv
module dpsk_phase_encoder
    import dpsk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [MODE_W-1:0]  mode,
    input  logic               sym_valid,
    input  logic [SYM_W-1:0]   sym_word,
    output logic               pt_valid,
    output logic [PHASE_W-1:0] pt_phase,
    output logic               pt_amp
);

    phase_change_t chg;

    dpsk_change_decode u_decode (
        .mode (mode),
        .word (sym_word),
        .chg  (chg)
    );

    dpsk_phase_acc u_acc (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sym_valid),
        .chg       (chg),
        .out_valid (pt_valid),
        .phase     (pt_phase),
        .amp       (pt_amp)
    );

endmodule

// File: tb/test_dpsk_phase_encoder.sv
`timescale 1ns/1ps
module test_dpsk_phase_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'd0;
    logic       sym_valid = 1'b0;
    logic [3:0] sym_word = 4'd0;
    logic       pt_valid;
    logic [2:0] pt_phase;
    logic       pt_amp;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    dpsk_phase_encoder i_dpsk_phase_encoder (
        .clk(clk), .rst(rst), .mode(mode), .sym_valid(sym_valid),
        .sym_word(sym_word), .pt_valid(pt_valid), .pt_phase(pt_phase),
        .pt_amp(pt_amp)
    );

    // {mode, word, expected phase, expected amp}; cumulative from reset
    localparam int NV = 23;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 4'b0001, 3'd0, 1'b0},  // R1
        {3'd0, 4'b0000, 3'd1, 1'b0},
        {3'd0, 4'b0010, 3'd3, 1'b0},
        {3'd0, 4'b0011, 3'd6, 1'b0},
        {3'd0, 4'b0111, 3'd2, 1'b0},
        {3'd0, 4'b0110, 3'd7, 1'b0},
        {3'd0, 4'b0100, 3'd5, 1'b0},
        {3'd0, 4'b0101, 3'd4, 1'b0},
        {3'd1, 4'b0000, 3'd4, 1'b0},  // R2
        {3'd1, 4'b0001, 3'd6, 1'b0},
        {3'd1, 4'b0011, 3'd2, 1'b0},
        {3'd1, 4'b0010, 3'd0, 1'b0},
        {3'd2, 4'b0000, 3'd2, 1'b0},  // R3
        {3'd2, 4'b0001, 3'd2, 1'b0},
        {3'd2, 4'b0011, 3'd0, 1'b0},
        {3'd2, 4'b0010, 3'd4, 1'b0},
        {3'd3, 4'b1011, 3'd7, 1'b1},  // R4
        {3'd3, 4'b0110, 3'd4, 1'b0},
        {3'd3, 4'b1001, 3'd4, 1'b1},
        {3'd4, 4'b1111, 3'd0, 1'b0},  // R5
        {3'd4, 4'b0000, 3'd1, 1'b0},
        {3'd4, 4'b1100, 3'd7, 1'b0},
        {3'd5, 4'b1111, 3'd7, 1'b0}   // R10
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one symbol at a falling edge; results are sampled one falling edge later
    task automatic send(input logic [2:0] m, input logic [3:0] w);
        mode = m; sym_word = w; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic check_point(input string req, input logic [2:0] ph, input logic a);
        check({req, " valid"}, {3'b0, pt_valid}, 4'd1);
        check({req, " phase"}, {1'b0, pt_phase}, {1'b0, ph});
        check({req, " amp"},   {3'b0, pt_amp},   {3'b0, a});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sym_valid = 1'b1;                 // R8: strobe during reset is ignored
        repeat (3) @(negedge clk);
        sym_valid = 1'b0;
        check("R8 reset valid", {3'b0, pt_valid}, 4'd0);
        check("R8 reset phase", {1'b0, pt_phase}, 4'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after release", {3'b0, pt_valid}, 4'd0);

        // table walk (R1..R6, R10), back-to-back strobes
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][10:8], VEC[i][7:4]);
            check_point($sformatf("R6 vec%0d", i), VEC[i][3:1], VEC[i][0]);
        end

        // R7: pulse is single and outputs hold while idle
        mode = 3'd0; sym_word = 4'b0111;
        @(negedge clk);
        check("R7 pulse ends", {3'b0, pt_valid}, 4'd0);
        check("R7 phase holds", {1'b0, pt_phase}, 4'd7);

        // R9: idle mode change leaves accumulator alone
        mode = 3'd3; sym_word = 4'b1000;
        repeat (2) @(negedge clk);
        mode = 3'd1;
        @(negedge clk);
        check("R9 idle valid", {3'b0, pt_valid}, 4'd0);
        send(3'd1, 4'b0001);              // +2 from 7 -> 1
        check_point("R9 after mode change", 3'd1, 1'b0);

        // R8: mid-stream reset, strobe held during reset
        rst = 1'b1; sym_valid = 1'b1; sym_word = 4'b0010; mode = 3'd0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; sym_valid = 1'b0;
        check("R8 midstream phase", {1'b0, pt_phase}, 4'd0);
        check("R8 midstream valid", {3'b0, pt_valid}, 4'd0);
        @(negedge clk);
        send(3'd0, 4'b0000);              // +1 from 0
        check_point("R8 restart", 3'd1, 1'b0);

        // R4 then R5: amplitude bit follows Q1, then fallback drops it
        send(3'd3, 4'b1001);
        check_point("R4 amp high", 3'd1, 1'b1);
        send(3'd4, 4'b1001);
        check_point("R5 amp forced low", 3'd1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule